// File: doc/BRIEF.md
# Serial GF(2) Polynomial Divider Array

The block divides a dividend polynomial A of degree N by a monic divisor polynomial B of degree M, with every coefficient a single bit and all arithmetic over GF(2). It is a chain of M one-bit cells. Each cell keeps one fixed low coefficient of B, a partial-remainder bit and a forwarded quotient bit. Dividend bits enter the rightmost cell (index 0) highest degree first, one per clock cycle. Partial remainders move leftward one cell per half cycle. The leftmost cell (index M−1) produces the quotient bit, and that bit travels back to the right through the per-cell quotient registers.

Cells with an even index update on the rising clock edge and cells with an odd index on the falling edge. Cell j therefore runs division step s at half-cycle 2s − j, where half-cycle 0 is the first rising edge after clear is released. A feedback-enable input drives the selector at the leftmost cell. When it is low, the returned quotient is zero and the chain becomes a plain shift register, so the remainder left in the cells can be read out serially at the leftmost cell. The quotient appears at the rightmost cell, one coefficient per cycle, together with a valid flag.

Top module: `gf2div_array`

## Requirements
- R1: While rst_ni is low, or after clr_i has been high for two full cycles, q_o, q_valid_o and rem_o are 0 and every cell holds a zero partial remainder.
- R2: b_i is captured on a rising edge while b_load_i is high, and bit j feeds cell j. The degree-M coefficient of the divisor is fixed at 1. b_i has no effect while b_load_i is low.
- R3: Rising edge t, counted from 0 at the first rising edge with clr_i low, samples dividend coefficient a_(N−t) on a_i. After the leftmost cell's step s, at half-cycle 2s−(M−1), rem_o equals quotient coefficient q_(N−1−s) for s = M−1 … N−1.
- R4: q_valid_o is high after rising edges t = M … N, which is N−M+1 cycles. It is low before and after that window until the next clear.
- R5: After rising edge t with t in M … N, q_o equals quotient coefficient q_(N−t). In all other cycles q_o is 0.
- R6: Cells with an even index change only on rising edges, and cells with an odd index change only on falling edges. rem_o holds its value across edges of the other polarity.
- R7: fb_en_i low at the leftmost cell's edge makes the returned quotient 0, and each cell then copies its right neighbour. With fb_en_i high at half-cycles h where h+M−1 ≤ 2N and low afterwards, rem_o gives remainder coefficients r_(M−1) down to r_0 after the leftmost cell's steps N … N+M−1.
- R8: Only the leftmost cell samples fb_en_i. A zero quotient selected there reaches cell j after M−1−j further half cycles, so q_o stays 0 after rising edges t > N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. Even cells use the rising edge, odd cells the falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all cell and counter state |
| b_load_i | input | 1 | Capture enable for the divisor coefficients |
| b_i | input | M | Divisor coefficients b_(M−1) … b_0 |
| a_i | input | 1 | Serial dividend coefficient, highest degree first |
| fb_en_i | input | 1 | Quotient feedback enable at the leftmost cell |
| q_o | output | 1 | Serial quotient bit from the rightmost cell |
| q_valid_o | output | 1 | q_o carries a quotient coefficient |
| rem_o | output | 1 | Leftmost partial-remainder bit (serial remainder) |

## Verification
The bench sweeps every divisor and a spread of dividends for three configurations. These put the leftmost cell on a rising edge, on a falling edge, and use a single cell, and each result is compared with a long-division model. An edge assigned to the wrong cell, or one half cycle of skew lost, shifts rem_o by a step. That corrupts the look-ahead quotient during the quotient phase and the order of the shifted-out remainder. Feedback that keeps running after fb_en_i drops, or is cut on all cells at once, leaves divisor terms in the remainder and puts nonzero q_o bits after the window. An off-by-one valid counter flags the all-zero first step or drops q_0. After each division, b_i is inverted while the load is off, so a divisor register that follows b_i changes the results.

// File: rtl/gf2div_pkg.sv
`timescale 1ns/1ps
package gf2div_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  // even cells on the rising edge, odd cells on the falling edge
  function automatic edge_e cell_edge(input int idx);
    return (idx % 2 == 1) ? EDGE_FALL : EDGE_RISE;
  endfunction

endpackage

// File: rtl/gf2div_cell.sv
`timescale 1ns/1ps
module gf2div_cell
  import gf2div_pkg::*;
#(
  parameter edge_e EDGE = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic b_i,
  input  logic r_in_i,
  input  logic q_in_i,
  output logic r_o,
  output logic q_fwd_o
);

  logic r_q, q_q;
  logic r_d;

  assign r_d     = r_in_i ^ (q_in_i & b_i);
  assign r_o     = r_q;
  assign q_fwd_o = q_q;

  if (EDGE == EDGE_FALL) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= 1'b0;
        q_q <= 1'b0;
      end else if (clr_i) begin
        r_q <= 1'b0;
        q_q <= 1'b0;
      end else begin
        r_q <= r_d;
        q_q <= q_in_i;
      end
    end

    assert_clr_zero_R1: assert property (@(negedge clk_i) disable iff (!rst_ni)
      clr_i |=> (!r_o && !q_fwd_o));
    assert_shift_only_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!clr_i && !q_in_i) |=> (r_o == $past(r_in_i)));
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= 1'b0;
        q_q <= 1'b0;
      end else if (clr_i) begin
        r_q <= 1'b0;
        q_q <= 1'b0;
      end else begin
        r_q <= r_d;
        q_q <= q_in_i;
      end
    end

    assert_clr_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (!r_o && !q_fwd_o));
    assert_shift_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !q_in_i) |=> (r_o == $past(r_in_i)));
  end

endmodule

// File: rtl/gf2div_ctrl.sv
`timescale 1ns/1ps
module gf2div_ctrl #(
  parameter int N = 9,
  parameter int M = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic q_valid_o
);

  localparam int             CW    = $clog2(N + 3);
  localparam logic [CW-1:0]  LAST  = CW'(N + 2);
  localparam logic [CW-1:0]  FIRST = CW'(M + 1);
  localparam logic [CW-1:0]  FINAL = CW'(N + 1);

  // cnt = rising edges since clear released, saturating
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign q_valid_o = (cnt_q >= FIRST) && (cnt_q <= FINAL);

  assert_clr_novalid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_valid_o);

endmodule

// File: rtl/gf2div_array.sv
`timescale 1ns/1ps
module gf2div_array
  import gf2div_pkg::*;
#(
  parameter int N = 9,
  parameter int M = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         b_load_i,
  input  logic [M-1:0] b_i,
  input  logic         a_i,
  input  logic         fb_en_i,
  output logic         q_o,
  output logic         q_valid_o,
  output logic         rem_o
);

  localparam int LEAD = M - 1;

  logic [M-1:0] b_q;
  logic [M-1:0] r_w;
  logic [M-1:0] qf_w;
  logic         q_fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       b_q <= '0;
    else if (b_load_i) b_q <= b_i;
  end

  // feedback selector: only the leftmost cell sees fb_en_i
  assign q_fb = fb_en_i & r_w[LEAD];

  for (genvar j = 0; j < M; j++) begin : g_cell
    logic r_in, q_in;
    if (j == 0) begin : g_in_a
      assign r_in = a_i;
    end else begin : g_in_r
      assign r_in = r_w[j-1];
    end
    if (j == LEAD) begin : g_q_fb
      assign q_in = q_fb;
    end else begin : g_q_pipe
      assign q_in = qf_w[j+1];
    end

    gf2div_cell #(
      .EDGE (cell_edge(j))
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .b_i     (b_q[j]),
      .r_in_i  (r_in),
      .q_in_i  (q_in),
      .r_o     (r_w[j]),
      .q_fwd_o (qf_w[j])
    );
  end

  gf2div_ctrl #(
    .N (N),
    .M (M)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .q_valid_o (q_valid_o)
  );

  assign q_o   = qf_w[0];
  assign rem_o = r_w[LEAD];

  assert_b_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_load_i |=> $stable(b_q));

endmodule

// File: tb/gf2div_array_tb.sv
`timescale 1ns/1ps
module gf2div_lane #(
  parameter int N    = 9,
  parameter int M    = 5,
  parameter int NDIV = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_cmp,
  output int   n_bad
);

  localparam bit EXH = (NDIV == 0);
  localparam int ND  = EXH ? (1 << (N + 1)) : NDIV;
  localparam logic [63:0] AMASK = (64'd1 << (N + 1)) - 64'd1;

  logic         clr, bl, a, fb;
  logic [M-1:0] b;
  logic         q_w, qv_w, rem_w;

  gf2div_array #(.N(N), .M(M)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .clr_i     (clr),
    .b_load_i  (bl),
    .b_i       (b),
    .a_i       (a),
    .fb_en_i   (fb),
    .q_o       (q_w),
    .q_valid_o (qv_w),
    .rem_o     (rem_w)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s N=%0d M=%0d at %0t: actual=%0h expected=%0h", tag, N, M, $time, act, exp);
    end
  endtask

  function automatic void divide(input logic [63:0] av, input logic [63:0] bv,
                                 output logic [63:0] qv, output logic [63:0] rv);
    logic [63:0] w;
    logic [63:0] bf;
    w  = av;
    bf = bv | (64'd1 << M);
    qv = '0;
    for (int i = N; i >= M; i--) begin
      if (w[i]) begin
        qv[i-M] = 1'b1;
        w = w ^ (bf << (i - M));
      end
    end
    rv = w & ((64'd1 << M) - 64'd1);
  endfunction

  task automatic run_div(input logic [63:0] av, input logic [63:0] bv);
    logic [63:0] qx, rx;
    int hend;
    divide(av, bv, qx, rx);
    hend = 2 * N + M + 1;
    @(posedge clk); #1;
    clr = 1'b1; bl = 1'b1; b = bv[M-1:0]; a = 1'b0; fb = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R1 clear q_valid", 64'(qv_w), 64'd0);
    chk("R1 clear rem", 64'(rem_w), 64'd0);
    chk("R1 clear q", 64'(q_w), 64'd0);
    clr = 1'b0; bl = 1'b0; b = ~bv[M-1:0];  // R2: b_i ignored now
    a  = av[N];
    fb = 1'b1;
    for (int h = 0; h <= hend; h++) begin
      if (h % 2 == 0) @(posedge clk); else @(negedge clk);
      #1;
      if (h % 2 == 0) begin
        int t;
        bit ev;
        t  = h / 2;
        ev = (t >= M) && (t <= N);
        chk("R4 valid window", 64'(qv_w), 64'(ev));
        if (ev)         chk("R5 quotient", 64'(q_w), 64'(qx[N-t]));
        else if (t > N) chk("R8 quotient after cut", 64'(q_w), 64'd0);
        else            chk("R5 quotient idle", 64'(q_w), 64'd0);
      end
      if ((h + M - 1) % 2 == 0) begin
        int s;
        s = (h + M - 1) / 2;
        if (s >= M - 1 && s <= N - 1) chk("R3 leading bit", 64'(rem_w), 64'(qx[N-1-s]));
        if (s >= N && s <= N + M - 1)  chk("R7 remainder", 64'(rem_w), 64'(rx[N+M-1-s]));
      end else if (h >= 1) begin
        int s;
        s = (h + M - 2) / 2;
        if (s >= N && s <= N + M - 1)  chk("R6 hold other edge", 64'(rem_w), 64'(rx[N+M-1-s]));
      end
      begin
        int hn;
        hn = h + 1;
        if (hn % 2 == 0) a = (hn / 2 <= N) ? av[N-hn/2] : 1'b0;
        fb = (hn + M - 1 <= 2 * N);
      end
    end
  endtask

  initial begin
    done = 1'b0; n_cmp = 0; n_bad = 0;
    clr = 1'b0; bl = 1'b0; b = '0; a = 1'b0; fb = 1'b1;
    wait (rst_n === 1'b1);
    @(posedge clk); #1;
    chk("R1 reset q_valid", 64'(qv_w), 64'd0);
    chk("R1 reset rem", 64'(rem_w), 64'd0);
    chk("R1 reset q", 64'(q_w), 64'd0);
    for (int bi = 0; bi < (1 << M); bi++) begin
      for (int k = 0; k < ND; k++) begin
        logic [63:0] av;
        if (EXH)         av = 64'(k);
        else if (k == 1) av = AMASK;
        else             av = (64'(k * 149) ^ 64'(k * k * 7)) & AMASK;
        run_div(av, 64'(bi));
      end
    end
    done = 1'b1;
  end

endmodule

module gf2div_array_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic d_a, d_b, d_c;
  int   c_a, c_b, c_c, f_a, f_b, f_c;

  gf2div_lane #(.N(9), .M(5), .NDIV(20)) u_lane_a (.clk(clk), .rst_n(rst_n), .done(d_a), .n_cmp(c_a), .n_bad(f_a));
  gf2div_lane #(.N(6), .M(4), .NDIV(0))  u_lane_b (.clk(clk), .rst_n(rst_n), .done(d_b), .n_cmp(c_b), .n_bad(f_b));
  gf2div_lane #(.N(4), .M(1), .NDIV(0))  u_lane_c (.clk(clk), .rst_n(rst_n), .done(d_c), .n_cmp(c_c), .n_bad(f_c));

  initial begin
    #12 rst_n = 1'b1;
  end

  initial begin
    int cyc;
    int to;
    cyc = 0;
    to  = 0;
    while (!(d_a === 1'b1 && d_b === 1'b1 && d_c === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d_a === 1'b1 && d_b === 1'b1 && d_c === 1'b1)) begin
      to = 1;
      $display("FAIL R4 watchdog: actual=running expected=finished");
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             c_a + c_b + c_c + to, f_a + f_b + f_c + to);
    $finish;
  end

endmodule